// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block merges three reasons to hold a system in reset into one active-low request, which then drives an open-drain reset pad. The reasons are: the end of power-up, a supply that has fallen below its trip level, and a watchdog that nobody serviced in time. The supply condition comes from an external comparator as an already synchronised `supply_ok` flag. The watchdog is serviced on the pin that also acts as the serial chip select. A two-bit select from a control register picks the watchdog period.

Every duration is counted in ticks of one shared prescaler. The defaults give a 1 ms tick from a 50 MHz clock: a 200 ms reset stretch, watchdog periods of 1.4 s, 600 ms and 200 ms, and a 400 ns minimum kick width. A testbench can shrink all of these through parameters. A power-up, a supply failure and a watchdog timeout all end in the same stretched reset. A supply failure also pulls the output low directly, without waiting for a clock edge.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_req_n` is 0. After `rst_n` rises with `supply_ok` = 1, `rst_req_n` stays 0 until HOLD_TICKS prescaler ticks have passed, and then it goes to 1.
- R2: When `supply_ok` is 0, `rst_req_n` is 0 in that same cycle, without a clock edge, and it stays 0 for as long as `supply_ok` stays 0.
- R3: Each time `supply_ok` returns to 1, the stretch count starts again from zero. `rst_req_n` rises only after HOLD_TICKS ticks with no further drop.
- R4: Only a falling edge on `cs_kick` restarts the watchdog. If the pin is held steadily high, or steadily low after a single fall, the watchdog still times out one period after that fall.
- R5: A low pulse on `cs_kick` shorter than KICK_MIN clock cycles does not restart the watchdog. A low level held for at least KICK_MIN cycles after a fall does restart it.
- R6: The `wd_sel` encoding is: 2'b00 for WD_LONG ticks, 2'b01 for WD_MID ticks, 2'b10 for WD_SHORT ticks, and 2'b11 to disable the watchdog, in which case no timeout reset ever occurs.
- R7: A watchdog timeout drives `rst_req_n` to 0 for HOLD_TICKS ticks. A fresh watchdog period starts when the reset releases.
- R8: Any change of `wd_sel` restarts the watchdog period from zero.
- R9: While `supply_ok` is 0, and while any reset stretch is active, the watchdog count is held at zero.
- R10: When a supply drop and a watchdog expiry land on the same cycle or neighbouring cycles, the supply drop wins. Reset is asserted at once, and it is released a full HOLD_TICKS after the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| supply_ok | input | 1 | Synchronised flag from the comparator: 1 when the supply is above the trip level |
| cs_kick | input | 1 | Chip-select pin that also services the watchdog; asynchronous |
| wd_sel | input | 2 | Watchdog period select (encoding in R6) |
| rst_req_n | output | 1 | Reset request to the open-drain pad, active low |

## Verification
The two functions that can land in the same cycle are supply-fail detection and watchdog expiry. A release always happens on a tick edge, so the latency from release to an unkicked expiry is fixed. The bench first measures that latency. It then repeats the sequence, dropping `supply_ok` on each cycle from three before to one after the expected expiry. For every offset it checks two things: the output is low immediately, and release comes inside the full stretch window counted from the supply's return, never earlier.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  // Period in ticks for a given select; 0 means disabled.
  function automatic int unsigned wd_period(input logic [1:0] sel,
                                            input int unsigned t_long,
                                            input int unsigned t_mid,
                                            input int unsigned t_short);
    case (sel)
      WD_LONG:  return t_long;
      WD_MID:   return t_mid;
      WD_SHORT: return t_short;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, b, c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/supv_tick.sv
module supv_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = supv_pkg::cnt_width(DIV);

  logic [W-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     div_cnt <= '0;
    else if (div_cnt == W'(DIV - 1)) div_cnt <= '0;
    else                            div_cnt <= div_cnt + 1'b1;
  end

  assign tick = (div_cnt == W'(DIV - 1));

  generate
    if (DIV > 1) begin : g_chk
      a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/supv_kick.sv
module supv_kick #(
  parameter int unsigned KICK_MIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic kick
);
  localparam int unsigned KW = supv_pkg::cnt_width(KICK_MIN);

  logic [1:0]    sync_q;
  logic          pin_s;
  logic          pin_d;
  logic          fall;
  logic          armed;
  logic [KW-1:0] low_cnt;

  assign pin_s = sync_q[1];
  assign fall  = pin_d & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      pin_d  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin};
      pin_d  <= pin_s;
    end
  end

  // low_cnt = low cycles already seen since the fall (fall cycle counts as the first)
  always_comb begin
    if (pin_s)       kick = 1'b0;
    else if (fall)   kick = (KICK_MIN <= 1);
    else             kick = armed && (low_cnt == KW'(KICK_MIN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_cnt <= '0;
    end else if (kick) begin
      armed   <= 1'b0;
      low_cnt <= '0;
    end else if (fall) begin
      armed   <= 1'b1;
      low_cnt <= KW'(1);
    end else if (armed && !pin_s) begin
      low_cnt <= low_cnt + 1'b1;
    end else begin
      armed   <= 1'b0;
      low_cnt <= '0;
    end
  end

  a_r5_kick_on_low_level: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !pin_s);
  a_r5_kick_needs_width: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && KICK_MIN > 1) |-> $past(!pin_s));
  a_r4_no_kick_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_s && pin_d) |-> !kick);
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int unsigned T_LONG  = 1400,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       supply_ok,
  input  logic       in_reset,
  input  logic [1:0] sel,
  output logic       expire
);
  import supv_pkg::*;

  localparam int unsigned CW = cnt_width(max3(T_LONG, T_MID, T_SHORT));

  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  logic          clear;
  logic          at_limit;
  int unsigned   limit;

  assign limit    = wd_period(sel, T_LONG, T_MID, T_SHORT);
  assign at_limit = (cnt == CW'(limit - 1));
  assign clear    = (sel == WD_OFF) || !supply_ok || in_reset || kick || (sel != sel_q);
  assign expire   = !clear && tick && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= WD_OFF;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (clear)          cnt <= '0;
      else if (tick)      cnt <= at_limit ? '0 : cnt + 1'b1;
    end
  end

  a_r9_low_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> cnt == '0);
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> cnt == '0);
  a_r6_off_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == WD_OFF) |-> !expire);
  a_r8_sel_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |=> cnt == '0);
endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
  parameter int unsigned HOLD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic active
);
  localparam int unsigned HW = supv_pkg::cnt_width(HOLD);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (!supply_ok || wd_expire) begin
      active <= 1'b1;
      hcnt   <= '0;
    end else if (active && tick) begin
      if (hcnt == HW'(HOLD - 1)) begin
        active <= 1'b0;
        hcnt   <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  a_r7_expiry_starts_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (active && hcnt == '0));
  a_r3_drop_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (active && hcnt == '0));
  a_r1_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(tick) && $past(supply_ok)));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned TICK_DIV   = 50000,
  parameter int unsigned HOLD_TICKS = 200,
  parameter int unsigned WD_LONG    = 1400,
  parameter int unsigned WD_MID     = 600,
  parameter int unsigned WD_SHORT   = 200,
  parameter int unsigned KICK_MIN   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_kick,
  input  logic [1:0] wd_sel,
  output logic       rst_req_n
);
  logic tick;
  logic kick;
  logic wd_expire;
  logic hold_active;

  supv_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  supv_kick #(.KICK_MIN(KICK_MIN)) u_kick (
    .clk(clk), .rst_n(rst_n), .pin(cs_kick), .kick(kick)
  );

  supv_wdog #(.T_LONG(WD_LONG), .T_MID(WD_MID), .T_SHORT(WD_SHORT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .supply_ok(supply_ok), .in_reset(hold_active), .sel(wd_sel),
    .expire(wd_expire)
  );

  supv_hold #(.HOLD(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .wd_expire(wd_expire), .active(hold_active)
  );

  // Supply loss reaches the pad without waiting for a clock edge
  assign rst_req_n = supply_ok && !hold_active;

  a_r2_low_supply_pad: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !rst_req_n);
  a_r10_drop_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wd_expire);
  a_r7_expiry_drives_pad: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !rst_req_n);
endmodule

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
  localparam int DIV  = 4;
  localparam int HOLD = 10;
  localparam int TL   = 40;
  localparam int TM   = 20;
  localparam int TS   = 10;
  localparam int KM   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       cs_kick;
  logic [1:0] wd_sel;
  logic       rst_req_n;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #10 clk = ~clk;

  supv_reset_gen #(
    .TICK_DIV(DIV), .HOLD_TICKS(HOLD), .WD_LONG(TL), .WD_MID(TM),
    .WD_SHORT(TS), .KICK_MIN(KM)
  ) u_supv_reset_gen (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_kick(cs_kick),
    .wd_sel(wd_sel), .rst_req_n(rst_req_n)
  );

  // Bench view of the period table
  function automatic int period_of(input logic [1:0] s);
    int tbl [4] = '{TL, TM, TS, 0};
    return tbl[s];
  endfunction
  function automatic int hold_lo();           return (HOLD - 1) * DIV; endfunction
  function automatic int hold_hi();           return HOLD * DIV + 2;   endfunction
  function automatic int wd_lo(input int L);  return (L - 1) * DIV;    endfunction
  function automatic int wd_hi(input int L, input int extra);
    return L * DIV + 2 + extra;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int lo, input int hi);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, tag, act, lo, hi);
  endtask

  // Negedges until rst_req_n reads lvl
  task automatic measure(input logic lvl, input int maxc, output int n);
    n = 0;
    while (rst_req_n !== lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Cycles with rst_req_n equal to lvl over a span
  task automatic watch(input logic lvl, input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req_n === lvl) hits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n, hits, e_ref, gap, L;
    void'($urandom(32'd2718));
    rst_n = 1'b0; supply_ok = 1'b1; cs_kick = 1'b1; wd_sel = 2'b10;
    repeat (3) @(negedge clk);
    chk(rst_req_n === 1'b0, "R1 asserted in reset", rst_req_n, 0, 0);
    rst_n = 1'b1;
    measure(1'b1, 1000, n);
    chk_win("R1 power-up stretch", n, hold_lo(), hold_hi());

    // R4/R6: steady high pin, short period
    measure(1'b0, 1000, n);
    chk_win("R4 steady-high timeout (R6 sel=10)", n, wd_lo(period_of(2'b10)), wd_hi(period_of(2'b10), 0));
    measure(1'b1, 1000, n);
    chk_win("R7 timeout stretch length", n, hold_lo(), hold_hi());
    measure(1'b0, 1000, n);
    chk_win("R7 new period after release", n, wd_lo(TS), wd_hi(TS, 0));
    measure(1'b1, 1000, n);

    // R4: one fall, then held low
    cs_kick = 1'b0;
    measure(1'b0, 1000, n);
    chk_win("R4 steady-low timeout", n, wd_lo(TS), wd_hi(TS, KM + 4));
    cs_kick = 1'b1;
    measure(1'b1, 1000, n);

    // R6: other periods, select changed right after release
    for (int k = 0; k < 2; k++) begin
      wd_sel = 2'(k);
      L = period_of(2'(k));
      measure(1'b0, 1000, n);
      chk_win($sformatf("R6 period sel=%0d", k), n, wd_lo(L), wd_hi(L, 0));
      measure(1'b1, 1000, n);
    end

    // R6: disabled
    wd_sel = 2'b11;
    watch(1'b0, 3 * TL * DIV, hits);
    chk(hits == 0, "R6 disabled gives no reset", hits, 0, 0);

    // R8: select change mid-period restarts
    wd_sel = 2'b10;
    repeat ((TS - 3) * DIV) @(negedge clk);
    wd_sel = 2'b01;
    measure(1'b0, 1000, n);
    chk_win("R8 select change restarts period", n, wd_lo(TM), wd_hi(TM, 0));
    measure(1'b1, 1000, n);

    // R5: short glitches only
    n = 0;
    while (rst_req_n === 1'b1 && n < 2000) begin
      if (n % 12 == 0)      cs_kick = 1'b0;
      if (n % 12 == KM - 2) cs_kick = 1'b1;
      @(negedge clk);
      n++;
    end
    cs_kick = 1'b1;
    chk_win("R5 short glitches ignored", n, wd_lo(TM), wd_hi(TM, 0));
    measure(1'b1, 1000, n);

    // R4/R5: random valid kicks with interleaved glitches
    hits = 0;
    for (int it = 0; it < 25; it++) begin
      gap = 8 + int'($urandom % 32'(((TM - 2) * DIV) - KM - 16));
      cs_kick = 1'b0;
      for (int c = 0; c < KM + 1; c++) begin
        @(negedge clk);
        if (rst_req_n !== 1'b1) hits++;
      end
      cs_kick = 1'b1;
      for (int c = 0; c < gap; c++) begin
        if (c == gap / 2 && ($urandom % 2) == 1) cs_kick = 1'b0;
        if (c == gap / 2 + KM - 2) cs_kick = 1'b1;
        @(negedge clk);
        if (rst_req_n !== 1'b1) hits++;
      end
      cs_kick = 1'b1;
    end
    chk(hits == 0, "R4 regular kicks keep reset off", hits, 0, 0);
    measure(1'b0, 1000, n);
    measure(1'b1, 1000, n);

    // R2: immediate, held
    repeat (5) @(negedge clk);
    supply_ok = 1'b0;
    #1;
    chk(rst_req_n === 1'b0, "R2 immediate assertion", rst_req_n, 0, 0);
    watch(1'b1, 30, hits);
    chk(hits == 0, "R2 held while supply low", hits, 0, 0);
    supply_ok = 1'b1;
    measure(1'b1, 1000, n);
    chk_win("R3 stretch after supply return", n, hold_lo(), hold_hi());

    // R3: second drop mid-stretch restarts count
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat ((HOLD - 2) * DIV) @(negedge clk);
    chk(rst_req_n === 1'b0, "R3 still held mid-stretch", rst_req_n, 0, 0);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    measure(1'b1, 1000, n);
    chk_win("R3 count restarted from zero", n, hold_lo(), hold_hi());

    // R9: supply drop mid-period clears watchdog
    wd_sel = 2'b10;
    repeat (4 * DIV) @(negedge clk);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    measure(1'b1, 1000, n);
    measure(1'b0, 1000, e_ref);
    chk_win("R9 full period after supply event", e_ref, wd_lo(TS), wd_hi(TS, 0));
    measure(1'b1, 1000, n);

    // R10: supply drop swept around the expiry cycle
    for (int off = -3; off <= 1; off++) begin
      repeat (e_ref + off - 1) @(negedge clk);
      supply_ok = 1'b0;
      #1;
      chk(rst_req_n === 1'b0, $sformatf("R10 immediate at offset %0d", off), rst_req_n, 0, 0);
      repeat (6) @(negedge clk);
      supply_ok = 1'b1;
      measure(1'b1, 1000, n);
      chk_win($sformatf("R10 release from supply return, offset %0d", off), n, hold_lo(), hold_hi());
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule